// File: doc/BRIEF.md
# Five-Stage Pipeline Flush Controller

This block models how instructions move through an in-order pipeline of five stages: fetch, decode, operand read, execute and result write. The block supplies the fetch index. The surrounding logic returns the instruction at that index: a tag, a taken-branch flag and a branch target. Each stage holds a valid bit, the tag, the branch flag and the target, and all stages move forward by one place on every clock.

Branches are resolved only when they reach the result-write stage. At that point every younger stage is invalidated in the same cycle, and fetch restarts at the target on the next cycle. Each branch that is followed by more work therefore costs four bubble cycles. A cycle counter and a retire counter let the cycles per instruction be read directly.

A run starts with a `start` pulse. Instructions are fetched from index 0 until the fetch index reaches `prog_len`, and `done` rises once the pipeline has drained.

Top module: `pipe_flush_ctrl`

## Requirements
- R1: Synchronous active-high reset leaves every stage valid bit at 0, both counters at 0, `done` at 0, `retire` at 0 and `fetch_idx` at 0.
- R2: Fetch proceeds through consecutive indexes. Each instruction retires with its own tag on `retire_tag`, in program order, exactly four cycles after the cycle it was fetched in.
- R3: A run of m instructions with no taken branch takes m+4 counted cycles.
- R4: While a taken branch (`ins_branch`=1 when fetched) occupies the result-write stage (bit 4 of `stage_valid`), bits 3 down to 0 of `stage_valid` read 0 in that same cycle.
- R5: In the cycle after a taken branch retires, `fetch_idx` equals that branch's target. If the target is below `prog_len`, fetch stage bit 0 is valid in that cycle.
- R6: Every taken branch that is followed by another instruction on the executed path adds exactly 4 cycles. With b such branches, m retired instructions take m+4+4b cycles.
- R7: `retire_cnt` rises by one for each valid instruction that leaves the result-write stage, equals the number of `retire` strobes, and never counts a flushed instruction.
- R8: `done` rises once the fetch index is at or beyond `prog_len` and all stages are empty. All valid bits then read 0, and both counters hold their values until the next `start`. That `start` clears the counters and restarts fetch at index 0.
- R9: A `start` pulse while a run is in progress has no effect on fetch, timing or counts.
- R10: A branch flag carried by an instruction that is later flushed has no effect. A branch whose target is itself a branch is handled in turn. A branch that leaves nothing further to fetch adds no cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a run when no run is in progress |
| prog_len | input | IDX_W | Number of instruction slots; fetch stops at or beyond this index |
| ins_tag | input | TAG_W | Tag of the instruction at `fetch_idx` |
| ins_branch | input | 1 | Instruction at `fetch_idx` is a taken branch |
| ins_target | input | IDX_W | Target index of that branch |
| fetch_idx | output | IDX_W | Index being fetched this cycle |
| stage_valid | output | NSTAGE | Per-stage valid bits; bit 0 fetch, bit 4 result write |
| retire | output | 1 | A valid instruction leaves the result-write stage this cycle |
| retire_tag | output | TAG_W | Tag of the retiring instruction |
| done | output | 1 | Run complete and pipeline empty |
| cycle_cnt | output | CNT_W | Cycles counted since the run started |
| retire_cnt | output | CNT_W | Instructions retired since the run started |

## Verification
The hardest case to reach is a flush that overlaps other control events. Examples are a branch sitting in the shadow of another branch, a branch whose target is also a branch, and a branch that retires as the last instruction, with nothing valid behind it. Directed programs place branch flags at exactly those indexes. The bench derives the executed path from the same instruction table, predicts the retire cycle of every instruction, and checks the flush and redirect at the edges around each branch retirement. A mid-run start pulse is injected into one of these programs to confirm that nothing moves.

// File: rtl/pfc_pkg.sv
package pfc_pkg;

  typedef enum logic [1:0] {
    PF_IDLE = 2'd0,
    PF_RUN  = 2'd1,
    PF_DONE = 2'd2
  } pf_state_e;

  // index of the stage where branches resolve and instructions retire
  function automatic int pf_last_stage(input int nstage);
    return nstage - 1;
  endfunction

endpackage

// File: rtl/pfc_stage.sv
module pfc_stage #(
  parameter int TAG_W = 8,
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             kill,
  input  logic             in_valid,
  input  logic [TAG_W-1:0] in_tag,
  input  logic             in_br,
  input  logic [IDX_W-1:0] in_tgt,
  output logic             q_valid,
  output logic [TAG_W-1:0] q_tag,
  output logic             q_br,
  output logic [IDX_W-1:0] q_tgt
);

  logic take;
  assign take = in_valid & ~kill;

  always_ff @(posedge clk) begin
    if (rst) begin
      q_valid <= 1'b0;
      q_tag   <= '0;
      q_br    <= 1'b0;
      q_tgt   <= '0;
    end else begin
      q_valid <= take;
      if (take) begin
        q_tag <= in_tag;
        q_br  <= in_br;
        q_tgt <= in_tgt;
      end
    end
  end

  AST_STAGE_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !kill) |=> (q_valid && q_tag == $past(in_tag))); // R2

  AST_STAGE_KILL: assert property (@(posedge clk) disable iff (rst)
    kill |=> !q_valid); // R4

endmodule

// File: rtl/pfc_fetch.sv
module pfc_fetch #(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [IDX_W-1:0] prog_len,
  input  logic             flush,
  input  logic [IDX_W-1:0] redirect_idx,
  input  logic             younger_busy,
  output logic [IDX_W-1:0] fetch_idx,
  output logic             fetch_valid,
  output logic             running,
  output logic             launch,
  output logic             done
);

  import pfc_pkg::*;

  pf_state_e        state;
  logic             exhausted;
  logic [IDX_W-1:0] next_idx;
  logic             drains;

  function automatic logic [IDX_W-1:0] pick_next(
    input logic             redirect,
    input logic             advance,
    input logic [IDX_W-1:0] cur,
    input logic [IDX_W-1:0] tgt
  );
    if (redirect)     return tgt;
    else if (advance) return cur + 1'b1;
    else              return cur;
  endfunction

  assign running     = (state == PF_RUN);
  assign done        = (state == PF_DONE);
  assign launch      = start & ~running;
  assign exhausted   = (fetch_idx >= prog_len);
  assign fetch_valid = running & ~exhausted & ~flush;
  assign next_idx    = pick_next(flush, fetch_valid, fetch_idx, redirect_idx);
  assign drains      = running & ~fetch_valid & ~younger_busy & (next_idx >= prog_len);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= PF_IDLE;
      fetch_idx <= '0;
    end else if (launch) begin
      state     <= PF_RUN;
      fetch_idx <= '0;
    end else if (running) begin
      fetch_idx <= next_idx;
      if (drains) state <= PF_DONE;
    end
  end

  AST_REDIRECT: assert property (@(posedge clk) disable iff (rst)
    flush |=> (fetch_idx == $past(redirect_idx))); // R5

  AST_SEQ_FETCH: assert property (@(posedge clk) disable iff (rst)
    fetch_valid |=> (fetch_idx == $past(fetch_idx) + 1'b1)); // R2

  AST_LAUNCH_ZERO: assert property (@(posedge clk) disable iff (rst)
    launch |=> (running && fetch_idx == '0)); // R8

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (running && start && fetch_valid) |=> (fetch_idx != '0)); // R9

endmodule

// File: rtl/pfc_perf.sv
module pfc_perf #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             running,
  input  logic             retire,
  output logic [CNT_W-1:0] cycle_cnt,
  output logic [CNT_W-1:0] retire_cnt
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] v);
    return (v == CNT_MAX) ? v : v + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cycle_cnt  <= '0;
      retire_cnt <= '0;
    end else begin
      if (running) cycle_cnt  <= bump(cycle_cnt);
      if (retire)  retire_cnt <= bump(retire_cnt);
    end
  end

  AST_RETIRE_STEP: assert property (@(posedge clk) disable iff (rst)
    (retire && !clear && retire_cnt != CNT_MAX) |=> (retire_cnt == $past(retire_cnt) + 1'b1)); // R7

  AST_CYCLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!running && !clear) |=> $stable(cycle_cnt)); // R8

  AST_RETIRE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!retire && !clear) |=> $stable(retire_cnt)); // R7

endmodule

// File: rtl/pipe_flush_ctrl.sv
module pipe_flush_ctrl #(
  parameter int NSTAGE = 5,
  parameter int IDX_W  = 8,
  parameter int TAG_W  = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [IDX_W-1:0]  prog_len,
  input  logic [TAG_W-1:0]  ins_tag,
  input  logic              ins_branch,
  input  logic [IDX_W-1:0]  ins_target,
  output logic [IDX_W-1:0]  fetch_idx,
  output logic [NSTAGE-1:0] stage_valid,
  output logic              retire,
  output logic [TAG_W-1:0]  retire_tag,
  output logic              done,
  output logic [CNT_W-1:0]  cycle_cnt,
  output logic [CNT_W-1:0]  retire_cnt
);

  localparam int LAST = pfc_pkg::pf_last_stage(NSTAGE);

  logic [NSTAGE-1:0] raw_v;
  logic [NSTAGE-1:0] br_q;
  logic [TAG_W-1:0]  tag_q [NSTAGE];
  logic [IDX_W-1:0]  tgt_q [NSTAGE];

  logic resolve_taken;
  logic younger_busy;
  logic fetch_valid;
  logic running;
  logic launch;

  // a branch in the final stage flushes everything behind it
  assign resolve_taken = raw_v[LAST] & br_q[LAST];

  pfc_fetch #(.IDX_W(IDX_W)) u_fetch (
    .clk          (clk),
    .rst          (rst),
    .start        (start),
    .prog_len     (prog_len),
    .flush        (resolve_taken),
    .redirect_idx (tgt_q[LAST]),
    .younger_busy (younger_busy),
    .fetch_idx    (fetch_idx),
    .fetch_valid  (fetch_valid),
    .running      (running),
    .launch       (launch),
    .done         (done)
  );

  // stage 0 is the fetch slot, fed straight from the instruction inputs
  assign raw_v[0] = fetch_valid;
  assign tag_q[0] = ins_tag;
  assign br_q[0]  = ins_branch;
  assign tgt_q[0] = ins_target;

  for (genvar k = 1; k <= LAST; k++) begin : g_stage
    pfc_stage #(.TAG_W(TAG_W), .IDX_W(IDX_W)) u_stage (
      .clk      (clk),
      .rst      (rst),
      .kill     (resolve_taken),
      .in_valid (raw_v[k-1]),
      .in_tag   (tag_q[k-1]),
      .in_br    (br_q[k-1]),
      .in_tgt   (tgt_q[k-1]),
      .q_valid  (raw_v[k]),
      .q_tag    (tag_q[k]),
      .q_br     (br_q[k]),
      .q_tgt    (tgt_q[k])
    );
  end

  // younger stages read invalid in the cycle the branch resolves
  for (genvar k = 0; k < LAST; k++) begin : g_gate
    assign stage_valid[k] = raw_v[k] & ~resolve_taken;
  end
  assign stage_valid[LAST] = raw_v[LAST];

  assign younger_busy = |stage_valid[LAST-1:1];
  assign retire       = stage_valid[LAST];
  assign retire_tag   = tag_q[LAST];

  pfc_perf #(.CNT_W(CNT_W)) u_perf (
    .clk        (clk),
    .rst        (rst),
    .clear      (launch),
    .running    (running),
    .retire     (retire),
    .cycle_cnt  (cycle_cnt),
    .retire_cnt (retire_cnt)
  );

  AST_DONE_EMPTY: assert property (@(posedge clk) disable iff (rst)
    done |-> (stage_valid == '0)); // R8

  AST_RETIRE_IN_RUN: assert property (@(posedge clk) disable iff (rst)
    retire |-> (running && !done)); // R7

  AST_FLUSH_DRAINS: assert property (@(posedge clk) disable iff (rst)
    resolve_taken |=> (raw_v[LAST:1] == '0)); // R4

endmodule

// File: tb/tb_pipe_flush_ctrl.sv
`timescale 1ns/1ps
module tb_pipe_flush_ctrl;

  localparam int NSTAGE = 5;
  localparam int IDX_W  = 8;
  localparam int TAG_W  = 8;
  localparam int CNT_W  = 16;
  localparam int DEPTH  = 1 << IDX_W;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start = 1'b0;
  logic [IDX_W-1:0]  prog_len = '0;
  logic [TAG_W-1:0]  ins_tag;
  logic              ins_branch;
  logic [IDX_W-1:0]  ins_target;
  logic [IDX_W-1:0]  fetch_idx;
  logic [NSTAGE-1:0] stage_valid;
  logic              retire;
  logic [TAG_W-1:0]  retire_tag;
  logic              done;
  logic [CNT_W-1:0]  cycle_cnt;
  logic [CNT_W-1:0]  retire_cnt;

  logic [TAG_W-1:0] m_tag [DEPTH];
  logic             m_br  [DEPTH];
  logic [IDX_W-1:0] m_tgt [DEPTH];

  int n_checks = 0;
  int n_err    = 0;

  always #2 clk = ~clk;

  assign ins_tag    = m_tag[fetch_idx];
  assign ins_branch = m_br[fetch_idx];
  assign ins_target = m_tgt[fetch_idx];

  pipe_flush_ctrl #(.NSTAGE(NSTAGE), .IDX_W(IDX_W), .TAG_W(TAG_W), .CNT_W(CNT_W)) dut (
    .clk(clk), .rst(rst), .start(start), .prog_len(prog_len),
    .ins_tag(ins_tag), .ins_branch(ins_branch), .ins_target(ins_target),
    .fetch_idx(fetch_idx), .stage_valid(stage_valid), .retire(retire),
    .retire_tag(retire_tag), .done(done), .cycle_cnt(cycle_cnt), .retire_cnt(retire_cnt)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic clear_prog();
    for (int i = 0; i < DEPTH; i++) begin
      m_tag[i] = TAG_W'(i ^ 8'h5A);
      m_br[i]  = 1'b0;
      m_tgt[i] = '0;
    end
  endtask

  task automatic set_branch(input int idx, input int tgt);
    m_br[idx]  = 1'b1;
    m_tgt[idx] = IDX_W'(tgt);
  endtask

  // runs the loaded program; total_req names the requirement for the cycle total
  task automatic run_prog(input int len, input int poke_at, input string total_req);
    int exp_tag [DEPTH];
    int exp_t   [DEPTH];
    bit exp_br  [DEPTH];
    int exp_tgt [DEPTH];
    int m = 0, b_seen = 0, idx = 0, n = 0, k = 0, pend_tgt = 0, exp_total;
    bit pend = 0;
    while (idx < len && m < DEPTH) begin
      exp_tag[m] = int'(m_tag[idx]);
      exp_t[m]   = m + 4 + 4 * b_seen;
      exp_br[m]  = m_br[idx];
      exp_tgt[m] = int'(m_tgt[idx]);
      if (m_br[idx]) begin b_seen++; idx = int'(m_tgt[idx]); end
      else idx++;
      m++;
    end
    exp_total = exp_t[m-1] + 1;

    prog_len = IDX_W'(len);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(cycle_cnt == 0 && retire_cnt == 0 && fetch_idx == 0, "R8", "restart clears",
          longint'(cycle_cnt) + longint'(retire_cnt) + longint'(fetch_idx), 0);
    while (!done && k < 4000) begin
      start = (k == poke_at);
      if (pend) begin
        check(int'(fetch_idx) == pend_tgt, "R5", "redirect index", fetch_idx, pend_tgt);
        if (pend_tgt < len)
          check(stage_valid[0], "R5", "fetch valid at target", stage_valid[0], 1);
        pend = 0;
      end
      if (retire) begin
        if (n < m) begin
          check(int'(retire_tag) == exp_tag[n], "R2", "retire tag order", retire_tag, exp_tag[n]);
          check(int'(cycle_cnt) == exp_t[n], "R2", "retire cycle", cycle_cnt, exp_t[n]);
          if (exp_br[n]) begin
            check(stage_valid[NSTAGE-2:0] == '0, "R4", "younger stages flushed",
                  stage_valid[NSTAGE-2:0], 0);
            pend = 1;
            pend_tgt = exp_tgt[n];
          end
        end else begin
          check(0, "R10", "unexpected retire", n + 1, m);
        end
        n++;
      end
      @(negedge clk);
      k++;
    end
    start = 1'b0;
    if (pend)
      check(int'(fetch_idx) == pend_tgt, "R5", "redirect index at end", fetch_idx, pend_tgt);
    check(done, "R8", "done raised", done, 1);
    check(stage_valid == '0, "R8", "pipe empty at done", stage_valid, 0);
    check(int'(cycle_cnt) == exp_total, total_req, "total cycles", cycle_cnt, exp_total);
    check(int'(retire_cnt) == m, "R7", "retire count", retire_cnt, m);
    check(n == m, "R7", "retire strobes", n, m);
  endtask

  task automatic test_reset();
    @(negedge clk);
    @(negedge clk);
    check(stage_valid == '0, "R1", "valid in reset", stage_valid, 0);
    check(cycle_cnt == 0 && retire_cnt == 0, "R1", "counters in reset",
          longint'(cycle_cnt) + longint'(retire_cnt), 0);
    rst = 1'b0;
    @(negedge clk);
    check(!done && !retire, "R1", "done/retire after reset", {done, retire}, 0);
    check(fetch_idx == 0, "R1", "fetch index after reset", fetch_idx, 0);
  endtask

  task automatic test_straight();
    clear_prog();
    run_prog(6, -1, "R3");
  endtask

  task automatic test_one_branch();
    clear_prog();
    set_branch(2, 7);
    run_prog(12, -1, "R6");
  endtask

  task automatic test_branch_shadow();
    clear_prog();
    set_branch(1, 4);
    set_branch(2, 9);  // wrong path, must be ignored
    set_branch(4, 6);  // target of a branch is itself a branch
    run_prog(10, -1, "R10");
  endtask

  task automatic test_branch_last();
    clear_prog();
    set_branch(4, 5);
    run_prog(5, -1, "R10");
  endtask

  task automatic test_start_ignored();
    clear_prog();
    set_branch(2, 7);
    run_prog(12, 3, "R9");
  endtask

  task automatic test_done_hold();
    logic [CNT_W-1:0] c0, r0;
    c0 = cycle_cnt;
    r0 = retire_cnt;
    repeat (5) @(negedge clk);
    check(done, "R8", "done holds", done, 1);
    check(cycle_cnt == c0, "R8", "cycle count holds", cycle_cnt, c0);
    check(retire_cnt == r0 && !retire, "R8", "retire count holds", retire_cnt, r0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(0, "watchdog", "run ended", 0, 1);
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  initial begin
    clear_prog();
    test_reset();
    test_straight();
    test_done_hold();
    test_one_branch();
    test_branch_shadow();
    test_branch_last();
    test_start_ignored();
    test_done_hold();
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

endmodule